// File: doc/BRIEF.md
# Delayed Branch Sequencer

This block owns the program counter of a processor whose control transfers take effect one instruction late. The decoder presents, with each issued instruction, a request code and its operands (an immediate, a register value and the condition flag T). When the request is a transfer, the block does not redirect at once. It stores the target, raises one of two pending flags and lets the next instruction (the slot instruction) issue from the sequential address. When that slot instruction issues, the program counter jumps to the stored target. For a conditional transfer it jumps only if the condition captured at decode time was 1.

The block also keeps the link register used by calls and returns, and the status value restored by an exception return. It latches the trap number and produces exception codes for traps, undefined opcodes and transfers placed in a slot. Fetch, decode and the response to an exception are outside the block. A transfer still resolves after an offending slot instruction.

Top module: `dbr_seq`

## Requirements
- R1: While rst_n is low and after its release, pc_o equals RESET_PC (default 0x100), pr_o, sr_o and tra_o are 0, and dslot_o, dslot_cond_o and exc_valid_o are 0.
- R2: With no transfer pending, each cycle with issue_i high and req_i of 0 (none), or an unused code 13 to 15, advances pc_o by INSN_BYTES (default 2). A cycle with issue_i low changes no output except that it clears exc_valid_o.
- R3: An issued request outside a slot with code 1 (branch to imm_i), 2 (branch to imm_i + opnd_i) or 5 (jump to opnd_i) sets dslot_o and advances pc_o by only INSN_BYTES.
- R4: When the next instruction issues with dslot_o set, pc_o becomes the stored target and both pending flags clear. Idle cycles between the two instructions keep the flags and pc_o.
- R5: Codes 3 (call to imm_i), 4 (call to imm_i + opnd_i) and 6 (call to opnd_i) write the transfer's own pc_o + 2*INSN_BYTES into pr_o. Code 7 (return) takes the pr_o held at decode as its target.
- R6: Code 8 (exception return) loads sr_o from ssr_i, takes spc_i as the target and sets dslot_o.
- R7: Code 9 captures tbit_i and code 10 captures its inverse, and either sets dslot_cond_o with target imm_i. After the slot the branch is taken only if the captured bit is 1, otherwise pc_o advances by INSN_BYTES. Later changes of tbit_i have no effect.
- R8: Code 11 (trap), outside a slot, sets tra_o to imm_i[7:0] times two and reports exception code 0x160.
- R9: Code 12 (undefined instruction), outside a slot, reports exception code 0x180.
- R10: Any code from 1 to 12 issued while a flag is pending reports code 0x1A0. It leaves the stored target, pr_o, sr_o and tra_o unchanged, and the pending transfer still resolves as in R4 and R7.
- R11: exc_valid_o is high for exactly the one cycle after the issuing edge, and exc_code_o holds its value until the next exception.
- R12: dslot_o and dslot_cond_o are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_i | input | 1 | An instruction issues this cycle |
| req_i | input | 4 | Request code of the issuing instruction |
| imm_i | input | W | Immediate target, base or trap number |
| opnd_i | input | W | Register operand |
| tbit_i | input | 1 | Condition flag T at decode |
| ssr_i | input | W | Saved status value for exception return |
| spc_i | input | W | Saved program counter for exception return |
| pc_o | output | W | Program counter |
| pr_o | output | W | Link (procedure) register |
| sr_o | output | W | Status value restored by exception return |
| dslot_o | output | 1 | Unconditional transfer pending |
| dslot_cond_o | output | 1 | Conditional transfer pending |
| exc_valid_o | output | 1 | Exception code valid pulse |
| exc_code_o | output | 12 | Exception code |
| tra_o | output | W | Trap number times two |

## Verification
The properties assume that req_i, imm_i and the other operands only matter in a cycle with issue_i high, and that they are stable across each rising edge. The properties also assume that RESET_PC and every target are plain values, so arithmetic on pc_o wraps modulo 2^W. The stimulus changes every input only at falling edges. It covers all sixteen request codes, including the unused ones, both with and without a pending transfer, and it inserts idle cycles between a transfer and its slot.

// File: rtl/dbr_pkg.sv
package dbr_pkg;

   localparam int EXC_W = 12;

   localparam logic [EXC_W-1:0] EXC_TRAP = 12'h160;
   localparam logic [EXC_W-1:0] EXC_UNDEF = 12'h180;
   localparam logic [EXC_W-1:0] EXC_SLOT = 12'h1A0;

   typedef enum logic [3:0] {
      REQ_NONE   = 4'd0,
      REQ_BR     = 4'd1,
      REQ_BR_REL = 4'd2,
      REQ_CALL   = 4'd3,
      REQ_CALL_R = 4'd4,
      REQ_JUMP   = 4'd5,
      REQ_JCALL  = 4'd6,
      REQ_RET    = 4'd7,
      REQ_ERET   = 4'd8,
      REQ_BT     = 4'd9,
      REQ_BF     = 4'd10,
      REQ_TRAP   = 4'd11,
      REQ_UNDEF  = 4'd12
   } req_e;

   typedef enum logic [2:0] {
      SRC_IMM,
      SRC_IMM_OPND,
      SRC_OPND,
      SRC_LINK,
      SRC_SAVED
   } tsrc_e;

   typedef struct packed {
      logic  any;
      logic  xfer;
      logic  cond;
      logic  inv;
      logic  link;
      logic  eret;
      logic  trap;
      logic  undef;
      tsrc_e src;
   } dec_t;

   function automatic dec_t decode(input logic [3:0] code);
      dec_t d;
      d = '{any: 1'b0, xfer: 1'b0, cond: 1'b0, inv: 1'b0, link: 1'b0,
            eret: 1'b0, trap: 1'b0, undef: 1'b0, src: SRC_IMM};
      case (code)
         REQ_BR: begin
            d.xfer = 1'b1;
         end
         REQ_BR_REL: begin
            d.xfer = 1'b1;
            d.src  = SRC_IMM_OPND;
         end
         REQ_CALL: begin
            d.xfer = 1'b1;
            d.link = 1'b1;
         end
         REQ_CALL_R: begin
            d.xfer = 1'b1;
            d.link = 1'b1;
            d.src  = SRC_IMM_OPND;
         end
         REQ_JUMP: begin
            d.xfer = 1'b1;
            d.src  = SRC_OPND;
         end
         REQ_JCALL: begin
            d.xfer = 1'b1;
            d.link = 1'b1;
            d.src  = SRC_OPND;
         end
         REQ_RET: begin
            d.xfer = 1'b1;
            d.src  = SRC_LINK;
         end
         REQ_ERET: begin
            d.xfer = 1'b1;
            d.eret = 1'b1;
            d.src  = SRC_SAVED;
         end
         REQ_BT: begin
            d.xfer = 1'b1;
            d.cond = 1'b1;
         end
         REQ_BF: begin
            d.xfer = 1'b1;
            d.cond = 1'b1;
            d.inv  = 1'b1;
         end
         REQ_TRAP:  d.trap  = 1'b1;
         REQ_UNDEF: d.undef = 1'b1;
         default: ;
      endcase
      d.any = d.xfer | d.trap | d.undef;
      return d;
   endfunction

endpackage

// File: rtl/dbr_target.sv
module dbr_target
   import dbr_pkg::*;
#(
   parameter int W         = 32,
   parameter bit ALIGN_LSB = 1'b0
) (
   input  dec_t         dec,
   input  logic [W-1:0] imm,
   input  logic [W-1:0] opnd,
   input  logic [W-1:0] link,
   input  logic [W-1:0] saved_pc,
   input  logic         tbit,
   output logic [W-1:0] tgt,
   output logic         cond_bit
);

   logic [W-1:0] raw;

   always_comb begin
      case (dec.src)
         SRC_IMM_OPND: raw = imm + opnd;
         SRC_OPND:     raw = opnd;
         SRC_LINK:     raw = link;
         SRC_SAVED:    raw = saved_pc;
         default:      raw = imm;
      endcase
   end

   generate
      if (ALIGN_LSB) begin : g_align
         assign tgt = {raw[W-1:1], 1'b0};
      end else begin : g_raw
         assign tgt = raw;
      end
   endgenerate

   assign cond_bit = dec.inv ? ~tbit : tbit;

endmodule

// File: rtl/dbr_slot.sv
module dbr_slot
   import dbr_pkg::*;
#(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         issue,
   input  dec_t         dec,
   input  logic [W-1:0] tgt,
   input  logic         cond_bit,
   output logic         pend_u,
   output logic         pend_c,
   output logic         in_slot,
   output logic         take,
   output logic [W-1:0] dest
);

   logic cap_bit;

   assign in_slot = pend_u | pend_c;
   assign take    = pend_u | (pend_c & cap_bit);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_u  <= 1'b0;
         pend_c  <= 1'b0;
         cap_bit <= 1'b0;
         dest    <= '0;
      end else if (issue) begin
         if (in_slot) begin
            pend_u <= 1'b0;
            pend_c <= 1'b0;
         end else if (dec.xfer) begin
            dest    <= tgt;
            pend_u  <= ~dec.cond;
            pend_c  <= dec.cond;
            cap_bit <= cond_bit;
         end
      end
   end

endmodule

// File: rtl/dbr_exc.sv
module dbr_exc
   import dbr_pkg::*;
#(
   parameter int W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             issue,
   input  logic             in_slot,
   input  dec_t             dec,
   input  logic [7:0]       trap_no,
   output logic             valid,
   output logic [EXC_W-1:0] code,
   output logic [W-1:0]     tra
);

   logic hit_slot, hit_trap, hit_undef;

   assign hit_slot  = issue & in_slot & dec.any;
   assign hit_trap  = issue & ~in_slot & dec.trap;
   assign hit_undef = issue & ~in_slot & dec.undef;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid <= 1'b0;
         code  <= '0;
         tra   <= '0;
      end else begin
         valid <= hit_slot | hit_trap | hit_undef;
         if (hit_slot) begin
            code <= EXC_SLOT;
         end else if (hit_trap) begin
            code <= EXC_TRAP;
            tra  <= W'({trap_no, 1'b0});
         end else if (hit_undef) begin
            code <= EXC_UNDEF;
         end
      end
   end

endmodule

// File: rtl/dbr_seq.sv
module dbr_seq
   import dbr_pkg::*;
#(
   parameter int           W          = 32,
   parameter int           INSN_BYTES = 2,
   parameter logic [W-1:0] RESET_PC   = 'h100,
   parameter bit           ALIGN_LSB  = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             issue_i,
   input  logic [3:0]       req_i,
   input  logic [W-1:0]     imm_i,
   input  logic [W-1:0]     opnd_i,
   input  logic             tbit_i,
   input  logic [W-1:0]     ssr_i,
   input  logic [W-1:0]     spc_i,
   output logic [W-1:0]     pc_o,
   output logic [W-1:0]     pr_o,
   output logic [W-1:0]     sr_o,
   output logic             dslot_o,
   output logic             dslot_cond_o,
   output logic             exc_valid_o,
   output logic [EXC_W-1:0] exc_code_o,
   output logic [W-1:0]     tra_o
);

   localparam logic [W-1:0] STEP = W'(INSN_BYTES);
   localparam logic [W-1:0] LINK = W'(2 * INSN_BYTES);

   generate
      if (W < 16 || W > 64) begin : g_bad_width
         $error("dbr_seq: W must lie in 16..64");
      end
      if (INSN_BYTES != 2 && INSN_BYTES != 4) begin : g_bad_step
         $error("dbr_seq: INSN_BYTES must be 2 or 4");
      end
   endgenerate

   dec_t         dec;
   logic [W-1:0] tgt, dest;
   logic         cond_bit, in_slot, take;

   assign dec = decode(req_i);

   dbr_target #(.W(W), .ALIGN_LSB(ALIGN_LSB)) target_i (
      .dec      (dec),
      .imm      (imm_i),
      .opnd     (opnd_i),
      .link     (pr_o),
      .saved_pc (spc_i),
      .tbit     (tbit_i),
      .tgt      (tgt),
      .cond_bit (cond_bit)
   );

   dbr_slot #(.W(W)) slot_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .issue    (issue_i),
      .dec      (dec),
      .tgt      (tgt),
      .cond_bit (cond_bit),
      .pend_u   (dslot_o),
      .pend_c   (dslot_cond_o),
      .in_slot  (in_slot),
      .take     (take),
      .dest     (dest)
   );

   dbr_exc #(.W(W)) exc_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .issue   (issue_i),
      .in_slot (in_slot),
      .dec     (dec),
      .trap_no (imm_i[7:0]),
      .valid   (exc_valid_o),
      .code    (exc_code_o),
      .tra     (tra_o)
   );

   logic [W-1:0] pc_seq;
   assign pc_seq = pc_o + STEP;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pc_o <= RESET_PC;
         pr_o <= '0;
         sr_o <= '0;
      end else if (issue_i) begin
         pc_o <= (in_slot && take) ? dest : pc_seq;
         if (!in_slot && dec.link) pr_o <= pc_o + LINK;
         if (!in_slot && dec.eret) sr_o <= ssr_i;
      end
   end

endmodule

// File: rtl/dbr_seq_chk.sv
module dbr_seq_chk #(
   parameter int W          = 32,
   parameter int INSN_BYTES = 2
) (
   input logic         clk,
   input logic         rst_n,
   input logic         issue_i,
   input logic [3:0]   req_i,
   input logic [W-1:0] imm_i,
   input logic [W-1:0] opnd_i,
   input logic         tbit_i,
   input logic [W-1:0] ssr_i,
   input logic [W-1:0] spc_i,
   input logic [W-1:0] pc_o,
   input logic [W-1:0] pr_o,
   input logic [W-1:0] sr_o,
   input logic         dslot_o,
   input logic         dslot_cond_o,
   input logic         exc_valid_o,
   input logic [11:0]  exc_code_o,
   input logic [W-1:0] tra_o
);

   localparam logic [W-1:0] STEP = W'(INSN_BYTES);

   logic slot, is_req;
   assign slot   = dslot_o | dslot_cond_o;
   assign is_req = (req_i != 4'd0) && (req_i <= 4'd12);

   assert_flags_excl_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !(dslot_o && dslot_cond_o));

   assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !issue_i |=> $stable(pc_o) && $stable(pr_o) && $stable(sr_o));

   assert_seq_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      issue_i && !slot && req_i == 4'd0 |=> pc_o == $past(pc_o) + STEP);

   assert_defer_R3: assert property (@(posedge clk) disable iff (!rst_n)
      issue_i && !slot && req_i == 4'd1 |=> dslot_o && pc_o == $past(pc_o) + STEP);

   assert_slot_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      issue_i && slot |=> !dslot_o && !dslot_cond_o);

   assert_link_R5: assert property (@(posedge clk) disable iff (!rst_n)
      issue_i && !slot && req_i == 4'd3 |=> pr_o == $past(pc_o) + STEP + STEP);

   assert_eret_R6: assert property (@(posedge clk) disable iff (!rst_n)
      issue_i && !slot && req_i == 4'd8 |=> dslot_o && sr_o == $past(ssr_i));

   assert_trap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      issue_i && !slot && req_i == 4'd11 |=>
         exc_valid_o && exc_code_o == 12'h160 && tra_o == W'({$past(imm_i[7:0]), 1'b0}));

   assert_undef_R9: assert property (@(posedge clk) disable iff (!rst_n)
      issue_i && !slot && req_i == 4'd12 |=> exc_valid_o && exc_code_o == 12'h180);

   assert_slot_exc_R10: assert property (@(posedge clk) disable iff (!rst_n)
      issue_i && slot && is_req |=> exc_valid_o && exc_code_o == 12'h1A0);

   assert_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !issue_i |=> !exc_valid_o);

endmodule

bind dbr_seq dbr_seq_chk #(.W(W), .INSN_BYTES(INSN_BYTES)) chk_i (.*);

// File: tb/dbr_seq_tb_top.sv
module dbr_seq_tb_top;

   localparam int W = 32;
   localparam logic [31:0] RST_PC = 32'h100;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        issue_i = 1'b0;
   logic [3:0]  req_i = '0;
   logic [31:0] imm_i = '0, opnd_i = '0, ssr_i = '0, spc_i = '0;
   logic        tbit_i = 1'b0;
   logic [31:0] pc_o, pr_o, sr_o, tra_o;
   logic        dslot_o, dslot_cond_o, exc_valid_o;
   logic [11:0] exc_code_o;

   always #5 clk = ~clk;

   dbr_seq dut_i (
      .clk(clk), .rst_n(rst_n), .issue_i(issue_i), .req_i(req_i),
      .imm_i(imm_i), .opnd_i(opnd_i), .tbit_i(tbit_i), .ssr_i(ssr_i),
      .spc_i(spc_i), .pc_o(pc_o), .pr_o(pr_o), .sr_o(sr_o),
      .dslot_o(dslot_o), .dslot_cond_o(dslot_cond_o),
      .exc_valid_o(exc_valid_o), .exc_code_o(exc_code_o), .tra_o(tra_o)
   );

   int total = 0;
   int bad = 0;

   // reference state
   logic [31:0] m_pc, m_pr, m_sr, m_tra, m_dpc;
   bit          m_ds, m_dsc, m_cb, m_ev;
   logic [11:0] m_ec;

   task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   task automatic compare(string tag);
      chk(tag, "pc", pc_o, m_pc);
      chk(tag, "pr", pr_o, m_pr);
      chk(tag, "sr", sr_o, m_sr);
      chk(tag, "tra", tra_o, m_tra);
      chk(tag, "dslot", 32'(dslot_o), 32'(m_ds));
      chk(tag, "dslot_cond", 32'(dslot_cond_o), 32'(m_dsc));
      chk(tag, "exc_valid", 32'(exc_valid_o), 32'(m_ev));
      if (m_ev) chk(tag, "exc_code", 32'(exc_code_o), 32'(m_ec));
      chk("R12", "flags exclusive", 32'(dslot_o & dslot_cond_o), 32'd0);
   endtask

   task automatic model(bit iss, logic [3:0] k, logic [31:0] im, logic [31:0] rg, bit t);
      bit slot;
      bit isreq;
      m_ev = 1'b0;
      if (!iss) return;
      slot  = m_ds || m_dsc;
      isreq = (k >= 4'd1) && (k <= 4'd12);
      if (slot) begin
         if (isreq) begin
            m_ev = 1'b1;
            m_ec = 12'h1A0;
         end
         m_pc  = (m_ds || (m_dsc && m_cb)) ? m_dpc : m_pc + 32'd2;
         m_ds  = 1'b0;
         m_dsc = 1'b0;
      end else begin
         case (k)
            4'd1:  begin m_dpc = im;      m_ds = 1'b1; end
            4'd2:  begin m_dpc = im + rg; m_ds = 1'b1; end
            4'd3:  begin m_dpc = im;      m_ds = 1'b1; m_pr = m_pc + 32'd4; end
            4'd4:  begin m_dpc = im + rg; m_ds = 1'b1; m_pr = m_pc + 32'd4; end
            4'd5:  begin m_dpc = rg;      m_ds = 1'b1; end
            4'd6:  begin m_dpc = rg;      m_ds = 1'b1; m_pr = m_pc + 32'd4; end
            4'd7:  begin m_dpc = m_pr;    m_ds = 1'b1; end
            4'd8:  begin m_dpc = spc_i;   m_ds = 1'b1; m_sr = ssr_i; end
            4'd9:  begin m_dpc = im; m_dsc = 1'b1; m_cb = t; end
            4'd10: begin m_dpc = im; m_dsc = 1'b1; m_cb = !t; end
            4'd11: begin m_tra = {23'd0, im[7:0], 1'b0}; m_ev = 1'b1; m_ec = 12'h160; end
            4'd12: begin m_ev = 1'b1; m_ec = 12'h180; end
            default: ;
         endcase
         m_pc = m_pc + 32'd2;
      end
   endtask

   // called at a falling edge; returns at the next falling edge after checking
   task automatic step(bit iss, logic [3:0] k, logic [31:0] im, logic [31:0] rg, bit t,
                       string tag);
      issue_i = iss;
      req_i   = k;
      imm_i   = im;
      opnd_i  = rg;
      tbit_i  = t;
      model(iss, k, im, rg, t);
      @(posedge clk);
      @(negedge clk);
      compare(tag);
   endtask

   task automatic finish_run;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      m_pc = RST_PC; m_pr = '0; m_sr = '0; m_tra = '0; m_dpc = '0;
      m_ds = 0; m_dsc = 0; m_cb = 0; m_ev = 0; m_ec = '0;
      repeat (3) @(negedge clk);
      compare("R1");
      rst_n = 1'b1;
      @(negedge clk);
      compare("R1");

      // R2 sequential flow, idle and unused codes
      step(1, 4'd0, 0, 0, 0, "R2");
      step(1, 4'd0, 0, 0, 0, "R2");
      step(0, 4'd1, 32'h9000, 0, 0, "R2");
      step(1, 4'd13, 32'h9000, 0, 0, "R2");
      step(1, 4'd15, 0, 0, 0, "R2");

      // R3 and R4 plain transfers
      step(1, 4'd1, 32'h2000, 0, 0, "R3");
      step(1, 4'd0, 0, 0, 0, "R4");
      step(1, 4'd2, 32'h100, 32'h40, 0, "R3");
      step(0, 4'd0, 0, 0, 0, "R4");
      step(0, 4'd0, 0, 0, 0, "R4");
      step(1, 4'd0, 0, 0, 0, "R4");
      step(1, 4'd5, 0, 32'h3000, 0, "R3");
      step(1, 4'd0, 0, 0, 0, "R4");

      // R5 calls and return
      step(1, 4'd3, 32'h4000, 0, 0, "R5");
      step(1, 4'd0, 0, 0, 0, "R5");
      step(1, 4'd0, 0, 0, 0, "R5");
      step(1, 4'd7, 0, 0, 0, "R5");
      step(1, 4'd0, 0, 0, 0, "R5");
      step(1, 4'd4, 32'h500, 32'h22, 0, "R5");
      step(1, 4'd0, 0, 0, 0, "R5");
      step(1, 4'd6, 0, 32'h4400, 0, "R5");
      step(1, 4'd0, 0, 0, 0, "R5");
      step(1, 4'd7, 0, 0, 0, "R5");
      step(1, 4'd0, 0, 0, 0, "R5");

      // R6 exception return
      ssr_i = 32'h0000_00F1;
      spc_i = 32'h5000;
      step(1, 4'd8, 0, 0, 0, "R6");
      ssr_i = 32'h0;
      spc_i = 32'h0;
      step(1, 4'd0, 0, 0, 0, "R6");

      // R7 conditional forms, decode-time capture
      step(1, 4'd9, 32'h6000, 0, 1, "R7");
      step(1, 4'd0, 0, 0, 0, "R7");
      step(1, 4'd9, 32'h7000, 0, 0, "R7");
      step(1, 4'd0, 0, 0, 1, "R7");
      step(1, 4'd10, 32'h7100, 0, 0, "R7");
      step(1, 4'd0, 0, 0, 1, "R7");
      step(1, 4'd10, 32'h7200, 0, 1, "R7");
      step(1, 4'd0, 0, 0, 0, "R7");

      // R8, R9, R11 exceptions and pulse width
      step(1, 4'd11, 32'hA5, 0, 0, "R8");
      step(1, 4'd0, 0, 0, 0, "R11");
      step(1, 4'd12, 0, 0, 0, "R9");
      step(0, 4'd0, 0, 0, 0, "R11");
      step(1, 4'd11, 32'h3, 0, 0, "R8");
      step(0, 4'd12, 0, 0, 0, "R11");

      // R10 requests inside a slot
      step(1, 4'd1, 32'h8000, 0, 0, "R10");
      step(1, 4'd1, 32'h8800, 0, 0, "R10");
      step(1, 4'd3, 32'h8100, 0, 0, "R10");
      step(1, 4'd11, 32'h7F, 0, 0, "R10");
      step(1, 4'd9, 32'h9100, 0, 0, "R10");
      step(1, 4'd12, 0, 0, 0, "R10");
      step(1, 4'd8, 0, 0, 0, "R10");
      ssr_i = 32'hFFFF;
      step(1, 4'd8, 0, 0, 0, "R10");
      ssr_i = 32'h0;
      step(1, 4'd0, 0, 0, 0, "R10");

      // mixed stimulus against the reference model
      for (int i = 0; i < 400; i++) begin
         ssr_i = $urandom;
         spc_i = $urandom & 32'hFFFF_FFFE;
         step(($urandom % 5) != 0, 4'($urandom % 16),
              $urandom & 32'hFFFF_FFFE, $urandom & 32'hFFFF_FFFE,
              1'($urandom % 2), "mixed");
      end

      finish_run();
   end

endmodule